// File: doc/BRIEF.md
# Day-Hour-Minute-Second Real-Time Clock with Alarm

This block keeps wall-clock time as separate day, hour, minute and second counters, together with an alarm compare and a set of periodic event sources. A slow reference clock reaches the block as a one-cycle enable pulse, `ref_tick`, that is already in the system clock domain. A prescaler counts these pulses and makes one second out of a selectable number of them. Software reaches every register over a small register bus with 16-bit data.

Time advances only while the run bit in the control register is set. The block flags an alarm when a second step lands exactly on the programmed day and time. It also flags 1 Hz, 2 Hz and eight power-of-two sampling rates from 4 Hz up to 512 Hz. Every event is latched into a sticky status register that is cleared by writing ones to it. A single interrupt line reports any latched event whose enable bit is set.

The register bus has no back-pressure and is always ready. A read returns data in the same cycle, combinationally from `bus_addr`. A write takes effect at the next clock edge. Only word-aligned byte addresses (`bus_addr[1:0] == 0`) select a register.

Top module: `rtc_dhms`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The control register (byte offset 0x10) keeps bit 7 (run) and bits 6:5 (rate select) exactly as written. All of its other bits read 0.
- R3: While run is set, the seconds counter advances once per RATE_A reference ticks when the rate select is 00 or 11, once per RATE_B ticks for 01, and once per RATE_C ticks for 10. Ticks are counted from the most recent write to a time register or to the control register.
- R4: Seconds and minutes count 0 to 59 and hours count 0 to 23. A step from 23:59:59 clears them all and increments the day counter. The day counter is DAY_W bits wide and wraps to 0.
- R5: Writing a 1 to a status bit (offset 0x14) clears it, and writing a 0 leaves it unchanged. If an event sets a bit in the same cycle that a write clears it, the event wins.
- R6: While run is clear, the time counters hold their values and no status bit is set. Register writes still take effect.
- R7: `irq` is high exactly while some status bit and the same enable bit (offset 0x18) are both 1. Only bits 2, 4, 7 and 15:8 exist in the status and enable registers; all other bits read 0.
- R8: Status bit 4 is a 1 Hz source and bit 7 is a 2 Hz source. Bits 8+j run at 2^(j+2) Hz, from 4 Hz up to 512 Hz at bit 15. Over every second, counted from the last prescaler clear, a source at F Hz sets its bit exactly F times, and all sources fire on the same tick that advances the seconds counter.
- R9: Status bit 2 (alarm) sets on a second step whose new day, hour, minute and second equal the alarm registers. The bit stays set until software clears it.
- R10: Writing the time registers so that they equal the alarm does not set the alarm bit.
- R11: Offsets map as follows: 0x00 hour/minute (hours in bits 15:8, minutes in bits 7:0), 0x04 seconds, 0x08 alarm hour/minute (same layout as 0x00), 0x0C alarm seconds, 0x20 day count, 0x24 alarm day. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each rate parameter is at least 512, so that every accumulator wraps at most once per tick. They also assume that the rate select changes only through a control write, which clears the prescaler at the same edge. The counter range property is guarded so that it applies only when the time already holds a legal value. The stimulus therefore uses rates of 1000 to 1200 ticks per second and loads only legal times. It drives `ref_tick` as single-cycle pulses, back to back or with random gaps, and it keeps the ticks low around every register access.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NSRC = 10;
  localparam logic [3:0] IDX_HM   = 4'd0;
  localparam logic [3:0] IDX_SEC  = 4'd1;
  localparam logic [3:0] IDX_AHM  = 4'd2;
  localparam logic [3:0] IDX_ASEC = 4'd3;
  localparam logic [3:0] IDX_CTL  = 4'd4;
  localparam logic [3:0] IDX_STAT = 4'd5;
  localparam logic [3:0] IDX_IEN  = 4'd6;
  localparam logic [3:0] IDX_DAY  = 4'd8;
  localparam logic [3:0] IDX_ADAY = 4'd9;
  localparam int BIT_ALARM = 2;
  localparam logic [15:0] EVT_IMPL = 16'hFF94;

  // status bit position of periodic source k (frequency 2^k Hz)
  function automatic int src_bit(input int k);
    if (k == 0) return 4;
    else if (k == 1) return 7;
    else return k + 6;
  endfunction

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } hms_t;
endpackage

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
  import rtc_pkg::*;
#(
  parameter int unsigned RATE_A = 32768,
  parameter int unsigned RATE_B = 32000,
  parameter int unsigned RATE_C = 38400,
  parameter int unsigned NSRC_P = NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ref_tick,
  input  logic              clear,
  input  logic [1:0]        sel,
  output logic [NSRC_P-1:0] pulse
);
  localparam int unsigned MAX_AB   = (RATE_A > RATE_B) ? RATE_A : RATE_B;
  localparam int unsigned MAX_R    = (MAX_AB > RATE_C) ? MAX_AB : RATE_C;
  localparam int unsigned TOP_STEP = 1 << (NSRC_P - 1);
  localparam int unsigned ACC_W    = $clog2(MAX_R + TOP_STEP + 1);

  logic [ACC_W-1:0] rate_v;
  logic             step;

  always_comb begin
    unique case (sel)
      2'b01:   rate_v = ACC_W'(RATE_B);
      2'b10:   rate_v = ACC_W'(RATE_C);
      default: rate_v = ACC_W'(RATE_A);
    endcase
  end

  assign step = run & ref_tick & ~clear;

  generate
    for (genvar k = 0; k < int'(NSRC_P); k++) begin : g_src
      localparam logic [ACC_W-1:0] STEP = ACC_W'(1 << k);
      logic [ACC_W-1:0] acc_q;
      logic [ACC_W-1:0] sum;
      logic             wrap;

      assign sum      = acc_q + STEP;
      assign wrap     = (sum >= rate_v);
      assign pulse[k] = step & wrap;

      always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (clear)  acc_q <= '0;
        else if (step)   acc_q <= wrap ? (sum - rate_v) : sum;
      end

      // R3
      acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < rate_v);
    end
  endgenerate
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
#(
  parameter int unsigned DAY_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             ld_hm,
  input  logic             ld_sec,
  input  logic             ld_day,
  input  logic [4:0]       ld_hr_v,
  input  logic [5:0]       ld_mn_v,
  input  logic [5:0]       ld_sc_v,
  input  logic [DAY_W-1:0] ld_day_v,
  input  hms_t             alm,
  input  logic [DAY_W-1:0] alm_day,
  output hms_t             now,
  output logic [DAY_W-1:0] day,
  output logic             alarm_hit
);
  hms_t             nxt;
  logic [DAY_W-1:0] day_n;
  logic             sc_wrap, mn_wrap, hr_wrap, ld_any;

  assign ld_any  = ld_hm | ld_sec | ld_day;
  assign sc_wrap = (now.sc >= 6'd59);
  assign mn_wrap = (now.mn >= 6'd59);
  assign hr_wrap = (now.hr >= 5'd23);

  always_comb begin
    nxt.sc = sc_wrap ? 6'd0 : now.sc + 6'd1;
    nxt.mn = now.mn;
    nxt.hr = now.hr;
    day_n  = day;
    if (sc_wrap) begin
      nxt.mn = mn_wrap ? 6'd0 : now.mn + 6'd1;
      if (mn_wrap) begin
        nxt.hr = hr_wrap ? 5'd0 : now.hr + 5'd1;
        if (hr_wrap) day_n = day + 1'b1;
      end
    end
  end

  assign alarm_hit = adv && (nxt == alm) && (day_n == alm_day);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now <= '0;
      day <= '0;
    end else if (ld_any) begin
      if (ld_hm) begin
        now.hr <= ld_hr_v;
        now.mn <= ld_mn_v;
      end
      if (ld_sec) now.sc <= ld_sc_v;
      if (ld_day) day <= ld_day_v;
    end else if (adv) begin
      now <= nxt;
      day <= day_n;
    end
  end

  // R6
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ld_any) |=> ($stable(now) && $stable(day)));

  // R4
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld_any && now.sc <= 6'd59 && now.mn <= 6'd59 && now.hr <= 5'd23)
      |=> (now.sc <= 6'd59 && now.mn <= 6'd59 && now.hr <= 5'd23));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_pkg::*;
#(
  parameter int unsigned NSRC_P = NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC_P-1:0] src_pulse,
  input  logic              alarm_hit,
  input  logic              wr_stat,
  input  logic              wr_ien,
  input  logic [15:0]       wdata,
  output logic [15:0]       stat,
  output logic [15:0]       ien,
  output logic              irq
);
  logic [15:0] set_v;
  logic [15:0] clr_v;

  always_comb begin
    set_v = '0;
    set_v[BIT_ALARM] = alarm_hit;
    for (int k = 0; k < int'(NSRC_P); k++) set_v[src_bit(k)] = src_pulse[k];
  end

  assign clr_v = wr_stat ? wdata : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      ien  <= '0;
    end else begin
      stat <= ((stat & ~clr_v) | set_v) & EVT_IMPL;
      if (wr_ien) ien <= wdata & EVT_IMPL;
    end
  end

  assign irq = |(stat & ien);

  generate
    for (genvar b = 0; b < 16; b++) begin : g_chk
      if (EVT_IMPL[b]) begin : g_impl
        // R5
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_stat && wdata[b] && !set_v[b]) |=> !stat[b]);
        // R5
        keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (stat[b] && !(wr_stat && wdata[b])) |=> stat[b]);
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_dhms.sv
module rtc_dhms
  import rtc_pkg::*;
#(
  parameter int unsigned DAY_W  = 9,
  parameter int unsigned RATE_A = 32768,
  parameter int unsigned RATE_B = 32000,
  parameter int unsigned RATE_C = 38400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  logic [3:0]       idx;
  logic             hit, wr;
  logic             wr_hm, wr_sec, wr_day, wr_ctl, wr_stat, wr_ien;
  logic             wr_ahm, wr_asec, wr_aday;
  logic [2:0]       ctl_q;
  logic             run, clear;
  hms_t             alm_q, now;
  logic [DAY_W-1:0] alm_day_q, day;
  logic [NSRC-1:0]  pulse;
  logic             alarm_hit;
  logic [15:0]      stat, ien;

  assign idx     = bus_addr[5:2];
  assign hit     = bus_sel && (bus_addr[1:0] == 2'b00);
  assign wr      = hit && bus_we;
  assign wr_hm   = wr && (idx == IDX_HM);
  assign wr_sec  = wr && (idx == IDX_SEC);
  assign wr_day  = wr && (idx == IDX_DAY);
  assign wr_ctl  = wr && (idx == IDX_CTL);
  assign wr_stat = wr && (idx == IDX_STAT);
  assign wr_ien  = wr && (idx == IDX_IEN);
  assign wr_ahm  = wr && (idx == IDX_AHM);
  assign wr_asec = wr && (idx == IDX_ASEC);
  assign wr_aday = wr && (idx == IDX_ADAY);

  assign run   = ctl_q[2];
  assign clear = wr_hm | wr_sec | wr_day | wr_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      alm_q     <= '0;
      alm_day_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata[7:5];
      if (wr_ahm) begin
        alm_q.hr <= bus_wdata[12:8];
        alm_q.mn <= bus_wdata[5:0];
      end
      if (wr_asec) alm_q.sc  <= bus_wdata[5:0];
      if (wr_aday) alm_day_q <= bus_wdata[DAY_W-1:0];
    end
  end

  rtc_rate_gen #(
    .RATE_A(RATE_A), .RATE_B(RATE_B), .RATE_C(RATE_C), .NSRC_P(NSRC)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .ref_tick(ref_tick),
    .clear(clear), .sel(ctl_q[1:0]), .pulse(pulse)
  );

  rtc_timekeeper #(.DAY_W(DAY_W)) u_time (
    .clk(clk), .rst_n(rst_n), .adv(pulse[0]),
    .ld_hm(wr_hm), .ld_sec(wr_sec), .ld_day(wr_day),
    .ld_hr_v(bus_wdata[12:8]), .ld_mn_v(bus_wdata[5:0]),
    .ld_sc_v(bus_wdata[5:0]), .ld_day_v(bus_wdata[DAY_W-1:0]),
    .alm(alm_q), .alm_day(alm_day_q),
    .now(now), .day(day), .alarm_hit(alarm_hit)
  );

  rtc_irq_ctrl #(.NSRC_P(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .src_pulse(pulse), .alarm_hit(alarm_hit),
    .wr_stat(wr_stat), .wr_ien(wr_ien), .wdata(bus_wdata),
    .stat(stat), .ien(ien), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      unique case (idx)
        IDX_HM:   bus_rdata = {3'b000, now.hr, 2'b00, now.mn};
        IDX_SEC:  bus_rdata = {10'd0, now.sc};
        IDX_AHM:  bus_rdata = {3'b000, alm_q.hr, 2'b00, alm_q.mn};
        IDX_ASEC: bus_rdata = {10'd0, alm_q.sc};
        IDX_CTL:  bus_rdata = {8'd0, ctl_q, 5'd0};
        IDX_STAT: bus_rdata = stat;
        IDX_IEN:  bus_rdata = ien;
        IDX_DAY:  bus_rdata[DAY_W-1:0] = day;
        IDX_ADAY: bus_rdata[DAY_W-1:0] = alm_day_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pulse == '0 && !alarm_hit));
endmodule

// File: tb/test_rtc_dhms.sv
module test_rtc_dhms;
  localparam int RA = 1024;
  localparam int RB = 1000;
  localparam int RC = 1200;
  localparam logic [5:0] A_HM = 6'h00, A_SEC = 6'h04, A_AHM = 6'h08,
    A_ASEC = 6'h0C, A_CTL = 6'h10, A_STAT = 6'h14, A_IEN = 6'h18,
    A_DAY = 6'h20, A_ADAY = 6'h24, A_NONE = 6'h1C;

  logic clk = 0, rst_n = 0, ref_tick = 0, bus_sel = 0, bus_we = 0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  rtc_dhms #(.DAY_W(9), .RATE_A(RA), .RATE_B(RB), .RATE_C(RC)) i_rtc_dhms (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic int sbit(input int k);
    return (k == 0) ? 4 : (k == 1) ? 7 : k + 6;
  endfunction

  function automatic int rate_of(input int sel);
    return (sel == 1) ? RB : (sel == 2) ? RC : RA;
  endfunction

  // expected status after t ticks (t < rate) from a prescaler clear
  function automatic logic [15:0] exp_stat(input int t, input int rate);
    logic [15:0] v = '0;
    for (int k = 0; k < 10; k++) if (((t << k) / rate) >= 1) v[sbit(k)] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic ticks(input int n, input bit gaps);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (gaps && ($urandom % 3 == 0)) ref_tick = 0;
      else begin ref_tick = 1; k++; end
    end
    @(negedge clk);
    ref_tick = 0;
  endtask

  task automatic set_time(input int d, input int h, input int m, input int s);
    wr(A_DAY, 16'(d));
    wr(A_HM, {8'(h), 8'(m)});
    wr(A_SEC, 16'(s));
  endtask

  task automatic check_time(input string tag, input int d, input int h, input int m, input int s);
    logic [15:0] v;
    rd(A_DAY, v); chk({tag, " day"}, v, 32'(d));
    rd(A_HM, v);  chk({tag, " hm"}, v, {8'(h), 8'(m)});
    rd(A_SEC, v); chk({tag, " sec"}, v, 32'(s));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int cnt [10];
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_CTL, v);  chk("R1 ctl", v, 0);
    rd(A_STAT, v); chk("R1 stat", v, 0);
    rd(A_HM, v);   chk("R1 hm", v, 0);
    chk("R1 irq", irq, 0);

    // R2 control readback
    wr(A_CTL, 16'hFFFF); rd(A_CTL, v); chk("R2 ctl mask", v, 16'h00E0);
    wr(A_CTL, 16'h0080); rd(A_CTL, v); chk("R2 ctl run", v, 16'h0080);

    // R11 map and layout
    wr(A_AHM, 16'h0A1E); rd(A_AHM, v); chk("R11 alarm hm", v, 16'h0A1E);
    wr(A_ASEC, 16'h002D); rd(A_ASEC, v); chk("R11 alarm sec", v, 16'h002D);
    wr(A_ADAY, 16'h01FF); rd(A_ADAY, v); chk("R11 alarm day", v, 16'h01FF);
    rd(A_NONE, v); chk("R11 unmapped", v, 0);

    // R3 / R4 second step and full rollover
    set_time(5, 23, 59, 59);
    wr(A_STAT, 16'hFFFF);
    ticks(RA - 1, 1'b0); check_time("R3 before", 5, 23, 59, 59);
    ticks(1, 1'b0);      check_time("R4 rollover", 6, 0, 0, 0);
    set_time(511, 23, 59, 59);
    ticks(RA, 1'b1);     check_time("R4 day wrap", 0, 0, 0, 0);
    set_time(2, 10, 59, 59);
    ticks(RA, 1'b0);     check_time("R4 hour step", 2, 11, 0, 0);

    // R3 each rate select
    for (int s = 1; s < 4; s++) begin
      wr(A_CTL, 16'(16'h0080 | (s << 5)));
      set_time(1, 1, 1, 10);
      ticks(rate_of(s) - 1, 1'b0);
      rd(A_SEC, v); chk($sformatf("R3 sel%0d early", s), v, 10);
      ticks(1, 1'b0);
      rd(A_SEC, v); chk($sformatf("R3 sel%0d step", s), v, 11);
    end

    // R6 stopped
    wr(A_CTL, 16'h0000);
    set_time(1, 2, 3, 4);
    wr(A_STAT, 16'hFFFF);
    ticks(3000, 1'b1);
    check_time("R6 hold", 1, 2, 3, 4);
    rd(A_STAT, v); chk("R6 no events", v, 0);

    // R8 periodic counts over one second, with clears every cycle (R5 set wins)
    wr(A_CTL, 16'h0080);
    wr(A_SEC, 16'h0000);
    for (int k = 0; k < 10; k++) cnt[k] = 0;
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = A_STAT; bus_wdata = 16'hFFFF; ref_tick = 1;
    for (int i = 0; i < RA; i++) begin
      @(negedge clk);
      #1;
      for (int k = 0; k < 10; k++) if (bus_rdata[sbit(k)]) cnt[k]++;
    end
    ref_tick = 0; bus_sel = 0; bus_we = 0;
    for (int k = 0; k < 10; k++) chk($sformatf("R8 count src%0d", k), cnt[k], 1 << k);
    rd(A_STAT, v); chk("R8 aligned at second", v, 16'hFF90);

    // R5 write-one-to-clear
    wr(A_STAT, 16'h0000); rd(A_STAT, v); chk("R5 zero write", v, 16'hFF90);
    wr(A_STAT, 16'h8000); rd(A_STAT, v); chk("R5 one bit", v, 16'h7F90);

    // R7 interrupt gating and enable mask
    chk("R7 irq off", irq, 0);
    wr(A_IEN, 16'h0010); @(negedge clk); chk("R7 irq on", irq, 1);
    wr(A_IEN, 16'hFFFF); rd(A_IEN, v); chk("R7 ien mask", v, 16'hFF94);
    wr(A_STAT, 16'hFFFF); @(negedge clk); chk("R7 irq cleared", irq, 0);

    // R9 alarm on count
    wr(A_IEN, 16'h0004);
    wr(A_ADAY, 16'd7); wr(A_AHM, 16'h0000); wr(A_ASEC, 16'h0000);
    set_time(6, 23, 59, 58);
    wr(A_STAT, 16'hFFFF);
    ticks(RA, 1'b0);
    rd(A_STAT, v); chk("R9 not yet", v[2], 0); chk("R9 irq low", irq, 0);
    ticks(RA, 1'b0);
    rd(A_STAT, v); chk("R9 alarm set", v[2], 1); chk("R9 irq high", irq, 1);
    check_time("R9 at alarm", 7, 0, 0, 0);
    ticks(RA, 1'b0);
    rd(A_STAT, v); chk("R9 sticky", v[2], 1);
    wr(A_STAT, 16'h0004); rd(A_STAT, v); chk("R5 alarm cleared", v[2], 0);

    // R10 load equal to alarm
    set_time(7, 0, 0, 0);
    @(negedge clk);
    rd(A_STAT, v); chk("R10 no alarm on load", v[2], 0);

    // R8 / R3 random partial seconds
    for (int it = 0; it < 16; it++) begin
      int s, t, h, m, sc;
      s = $urandom % 4; t = $urandom % rate_of(s);
      h = $urandom % 24; m = $urandom % 60; sc = $urandom % 60;
      wr(A_CTL, 16'(16'h0080 | (s << 5)));
      set_time(3, h, m, sc);
      wr(A_STAT, 16'hFFFF);
      ticks(t, 1'b1);
      rd(A_STAT, v); chk($sformatf("R8 rand stat sel%0d t%0d", s, t), v, exp_stat(t, rate_of(s)));
      rd(A_SEC, v);  chk("R3 rand no step", v, 32'(sc));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule